// File: doc/BRIEF.md
# Dual-Mode 8-Bit PWM Timer

This block is a free-running timer/counter with a compare register that drives one PWM pin. In phase-correct mode the counter climbs from zero to all ones and then descends back to zero. In fast mode it climbs and wraps, so the output period is half as long. A small control register starts and stops counting, picks the mode and chooses what a compare event or a wrap does to the pin. A timer tick enable input sets the counting rate. The counter advances by one on each cycle in which the tick is high and counting is enabled.

Software reaches the counter, the compare value and the control bits through a register bus with a single address. Writes to the compare value are staged and only take effect at the top of the sweep (phase-correct) or at the wrap (fast), so the pin never shows a stretched or split pulse. A compare event raises a sticky interrupt flag one cycle later. A write-one-to-clear input drops the flag.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the control, counter and compare registers read 0, and `pwm_out` and `cmp_flag` are low. The register map is: address 0 is control (bit 0 run, bit 1 fast mode, bits 3:2 output mode), address 1 is the counter, address 2 is the compare value. Unused read bits return 0.
- R2: With fast mode clear, successive ticks move the counter up to 0xFF, then down to 0x00, then up again. A written value keeps the current direction.
- R3: With fast mode set, successive ticks move the counter up, and it wraps from 0xFF to 0x00.
- R4: The counter changes only on cycles where `tick_en` and run are both high. A counter write takes priority over a tick in the same cycle. The next tick continues from the written value.
- R5: A counter or compare write that makes the counter equal to the compare value causes no compare event and does not set the flag.
- R6: A compare event occurs in the cycle after counting brings the counter to the active compare value. `cmp_flag` rises one clock after that event.
- R7: `cmp_flag` stays set until a cycle with `cmp_flag_clr` high. If a compare event and a clear fall in the same cycle, the flag is set.
- R8: In fast mode, output mode 2 (binary 10) clears the pin on a compare event and sets it on a wrap, so with compare value C the pin is high C of every 256 ticks. Output mode 3 (binary 11) does the opposite, giving 256−C high ticks. If a wrap and a compare event coincide, the compare action wins.
- R9: In phase-correct mode, output mode 2 clears the pin on a compare event reached while counting up and sets it on one reached while counting down, giving 2·C high ticks out of a 510-tick period. Output mode 3 inverts both actions.
- R10: Output mode 1 (binary 01) toggles the pin on every compare event.
- R11: Output mode 0 holds the pin low.
- R12: While run is high, a compare write is held in a staging register. It becomes active when a tick brings the counter to 0xFF in phase-correct mode, or when a tick wraps it to 0x00 in fast mode. While run is low, a write is active at once. Address 2 reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| tick_en | input | 1 | Count tick enable |
| cmp_flag_clr | input | 1 | Clear for the compare flag |
| pwm_out | output | 1 | PWM output pin |
| cmp_flag | output | 1 | Sticky compare event flag |

## Verification
The hardest case to reach is proving that a compare write made mid-sweep stays inactive until the wrap. The old and new values both look plausible at the pin, so the test needs a window in which only one of them could match. The bench runs the counter freely and polls its value over the bus. It writes a lower compare value just after the counter passes zero, then shows the flag stays low past the new value and rises only after the old one. After the wrap, it shows the new value firing. A flag clear that lands in the same cycle as a compare event is reached by stepping single ticks, so the event cycle is known exactly.

// File: rtl/pwm_timer8_pkg.sv
`timescale 1ns/1ps
package pwm_timer8_pkg;

   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
   localparam logic [ADDR_W-1:0] A_CMP   = 2'd2;

   typedef enum logic [1:0] {
      OM_OFF    = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_NONINV = 2'b10,
      OM_INV    = 2'b11
   } out_mode_e;

   // bit 0 run, bit 1 fast, bits 3:2 output mode
   typedef struct packed {
      out_mode_e out_mode;
      logic      fast;
      logic      run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_cnt_core.sv
`timescale 1ns/1ps
module pwm_cnt_core #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             fast,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_val,
   output logic [WIDTH-1:0] cnt,
   output logic             moved,
   output logic             last_up,
   output logic             wrapped,
   output logic             load_pt
);
   localparam logic [WIDTH-1:0] MAX  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 4) begin : g_width_chk
      $error("pwm_cnt_core: WIDTH must be at least 4");
   end

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] nxt;
   logic             dir_up_q;
   logic             going_up;
   logic             moved_q;
   logic             last_up_q;
   logic             wrapped_q;

   // direction of the coming step
   always_comb begin
      if (fast) begin
         going_up = 1'b1;
      end else if (dir_up_q) begin
         going_up = (cnt_q != MAX);
      end else begin
         going_up = (cnt_q == ZERO);
      end
      nxt = going_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
   end

   // staged compare value becomes active on this step
   always_comb begin
      load_pt = 1'b0;
      if (step && !ld) begin
         if (fast) begin
            load_pt = (cnt_q == MAX);
         end else begin
            load_pt = going_up && (nxt == MAX);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         dir_up_q  <= 1'b1;
         moved_q   <= 1'b0;
         last_up_q <= 1'b1;
         wrapped_q <= 1'b0;
      end else if (ld) begin
         cnt_q     <= ld_val;
         moved_q   <= 1'b0;
         wrapped_q <= 1'b0;
      end else if (step) begin
         cnt_q     <= nxt;
         moved_q   <= 1'b1;
         last_up_q <= going_up;
         wrapped_q <= fast && (cnt_q == MAX);
         if (fast) begin
            dir_up_q <= 1'b1;
         end else if (going_up) begin
            dir_up_q <= (nxt != MAX);
         end else begin
            dir_up_q <= (nxt == ZERO);
         end
      end else begin
         moved_q   <= 1'b0;
         wrapped_q <= 1'b0;
      end
   end

   assign cnt     = cnt_q;
   assign moved   = moved_q;
   assign last_up = last_up_q;
   assign wrapped = wrapped_q;

endmodule

// File: rtl/pwm_cmp_unit.sv
`timescale 1ns/1ps
module pwm_cmp_unit #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             run,
   input  logic             load_pt,
   input  logic [WIDTH-1:0] cnt,
   input  logic             moved,
   input  logic             flag_clr,
   output logic [WIDTH-1:0] cmp_stage,
   output logic             match,
   output logic             flag
);
   if (WIDTH < 4) begin : g_width_chk
      $error("pwm_cmp_unit: WIDTH must be at least 4");
   end

   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] stage_nxt;
   logic [WIDTH-1:0] act_q;
   logic             flag_q;

   assign stage_nxt = wr ? wdata : stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         act_q   <= '0;
      end else begin
         stage_q <= stage_nxt;
         if (!run || load_pt) begin
            act_q <= stage_nxt;
         end
      end
   end

   // only a counted arrival qualifies as an event
   assign match = moved && (cnt == act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign cmp_stage = stage_q;
   assign flag      = flag_q;

endmodule

// File: rtl/pwm_wave_gen.sv
`timescale 1ns/1ps
module pwm_wave_gen
   import pwm_timer8_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  out_mode_e out_mode,
   input  logic      fast,
   input  logic      match,
   input  logic      wrapped,
   input  logic      last_up,
   output logic      pwm
);
   logic pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         unique case (out_mode)
            OM_OFF: pwm_q <= 1'b0;
            OM_TOGGLE: begin
               if (match) pwm_q <= ~pwm_q;
            end
            OM_NONINV: begin
               if (fast) begin
                  if (match)        pwm_q <= 1'b0;
                  else if (wrapped) pwm_q <= 1'b1;
               end else if (match) begin
                  pwm_q <= ~last_up;
               end
            end
            OM_INV: begin
               if (fast) begin
                  if (match)        pwm_q <= 1'b1;
                  else if (wrapped) pwm_q <= 1'b0;
               end else if (match) begin
                  pwm_q <= last_up;
               end
            end
            default: pwm_q <= 1'b0;
         endcase
      end
   end

   assign pwm = pwm_q;

endmodule

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8
   import pwm_timer8_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr,
   input  logic [pwm_timer8_pkg::ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]               bus_wdata,
   output logic [WIDTH-1:0]               bus_rdata,
   input  logic                           tick_en,
   input  logic                           cmp_flag_clr,
   output logic                           pwm_out,
   output logic                           cmp_flag
);
   if (WIDTH < CTRL_W) begin : g_width_chk
      $error("pwm_timer8: WIDTH must hold the control bits");
   end

   ctrl_t            ctrl_q;
   logic             wr_ctrl;
   logic             wr_cnt;
   logic             wr_cmp;
   logic             step;
   logic [WIDTH-1:0] cnt_w;
   logic [WIDTH-1:0] stage_w;
   logic             moved_w;
   logic             last_up_w;
   logic             wrapped_w;
   logic             load_pt_w;
   logic             match_w;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
   assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
   assign step    = ctrl_q.run && tick_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
         A_COUNT: bus_rdata = cnt_w;
         A_CMP:   bus_rdata = stage_w;
         default: bus_rdata = '0;
      endcase
   end

   pwm_cnt_core #(.WIDTH(WIDTH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .fast    (ctrl_q.fast),
      .ld      (wr_cnt),
      .ld_val  (bus_wdata),
      .cnt     (cnt_w),
      .moved   (moved_w),
      .last_up (last_up_w),
      .wrapped (wrapped_w),
      .load_pt (load_pt_w)
   );

   pwm_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_cmp),
      .wdata     (bus_wdata),
      .run       (ctrl_q.run),
      .load_pt   (load_pt_w),
      .cnt       (cnt_w),
      .moved     (moved_w),
      .flag_clr  (cmp_flag_clr),
      .cmp_stage (stage_w),
      .match     (match_w),
      .flag      (cmp_flag)
   );

   pwm_wave_gen u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_mode (ctrl_q.out_mode),
      .fast     (ctrl_q.fast),
      .match    (match_w),
      .wrapped  (wrapped_w),
      .last_up  (last_up_w),
      .pwm      (pwm_out)
   );

endmodule

// File: rtl/pwm_timer8_chk.sv
`timescale 1ns/1ps
module pwm_timer8_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic             tick_en,
   input logic             cmp_flag_clr,
   input logic             pwm_out,
   input logic             cmp_flag,
   input logic [3:0]       ctrl,
   input logic [WIDTH-1:0] cnt,
   input logic             match
);
   localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

   logic cnt_wr;
   logic stepping;
   assign cnt_wr   = bus_wr && (bus_addr == 2'd1);
   assign stepping = tick_en && ctrl[0] && !cnt_wr;

   // R3
   fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && ctrl[1] && cnt == MAX) |=> (cnt == '0));

   // R2
   turn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && !ctrl[1] && cnt == MAX) |=> (cnt == MAX - 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick_en && ctrl[0]) && !cnt_wr) |=> $stable(cnt));

   // R4
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(bus_wdata)));

   // R5
   no_sw_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !match);

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> cmp_flag);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag_clr && !match) |=> !cmp_flag);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !cmp_flag_clr && !match) |=> cmp_flag);

   // R11
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3:2] == 2'b00) |=> !pwm_out);

endmodule

bind pwm_timer8 pwm_timer8_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .tick_en      (tick_en),
   .cmp_flag_clr (cmp_flag_clr),
   .pwm_out      (pwm_out),
   .cmp_flag     (cmp_flag),
   .ctrl         (ctrl_q),
   .cnt          (cnt_w),
   .match        (match_w)
);

// File: tb/pwm_timer8_bench.sv
`timescale 1ns/1ps
module pwm_timer8_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       tick_en = 1'b0;
   logic       cmp_flag_clr = 1'b0;
   logic       pwm_out;
   logic       cmp_flag;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pwm_timer8 #(.WIDTH(8)) u_pwm_timer8 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .tick_en      (tick_en),
      .cmp_flag_clr (cmp_flag_clr),
      .pwm_out      (pwm_out),
      .cmp_flag     (cmp_flag)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      tick_en = 1'b0; bus_wr = 1'b0; cmp_flag_clr = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic one_tick();
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic wait_cnt(input int val);
      int v;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         rd_reg(2'd1, v);
         if (v == val) break;
      end
   endtask

   task automatic count_high(input int n, output int hi, output int edges);
      logic prev;
      hi = 0; edges = 0;
      prev = pwm_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
         if (pwm_out != prev) edges++;
         prev = pwm_out;
      end
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      rd_reg(2'd0, v); check_eq("R1 ctrl", v, 0);
      rd_reg(2'd1, v); check_eq("R1 counter", v, 0);
      rd_reg(2'd2, v); check_eq("R1 compare", v, 0);
      check_eq("R1 pwm", int'(pwm_out), 0);
      check_eq("R1 flag", int'(cmp_flag), 0);
   endtask

   task automatic t_updown();
      int v;
      int exp_seq[4] = '{8'hFE, 8'hFF, 8'hFE, 8'hFD};
      do_reset();
      wr_reg(2'd1, 8'hFD);
      wr_reg(2'd0, 8'h01);
      foreach (exp_seq[i]) begin
         one_tick();
         rd_reg(2'd1, v); check_eq("R2 up/down sequence", v, exp_seq[i]);
      end
      wr_reg(2'd1, 8'h01);
      one_tick(); rd_reg(2'd1, v); check_eq("R2 reach bottom", v, 0);
      one_tick(); rd_reg(2'd1, v); check_eq("R2 turn up", v, 1);
   endtask

   task automatic t_fast();
      int v;
      int exp_seq[4] = '{8'hFE, 8'hFF, 8'h00, 8'h01};
      do_reset();
      wr_reg(2'd1, 8'hFD);
      wr_reg(2'd0, 8'h03);
      foreach (exp_seq[i]) begin
         one_tick();
         rd_reg(2'd1, v); check_eq("R3 wrap sequence", v, exp_seq[i]);
      end
   endtask

   task automatic t_tick_and_write();
      int v;
      do_reset();
      wr_reg(2'd1, 8'h10);
      tick_en = 1'b1;
      repeat (5) @(negedge clk);
      rd_reg(2'd1, v); check_eq("R4 stopped ignores tick", v, 8'h10);
      wr_reg(2'd0, 8'h03);
      wr_reg(2'd1, 8'h40);
      rd_reg(2'd1, v); check_eq("R4 write beats tick", v, 8'h40);
      @(negedge clk);
      rd_reg(2'd1, v); check_eq("R4 resume after write", v, 8'h41);
      tick_en = 1'b0;
   endtask

   task automatic t_no_sw_match();
      do_reset();
      wr_reg(2'd2, 8'h20);
      wr_reg(2'd0, 8'h03);
      wr_reg(2'd1, 8'h20);
      repeat (3) @(negedge clk);
      check_eq("R5 counter write no match", int'(cmp_flag), 0);
      wr_reg(2'd0, 8'h02);
      wr_reg(2'd1, 8'h30);
      wr_reg(2'd2, 8'h30);
      repeat (3) @(negedge clk);
      check_eq("R5 compare write no match", int'(cmp_flag), 0);
   endtask

   task automatic t_flag();
      do_reset();
      wr_reg(2'd2, 8'h20);
      wr_reg(2'd1, 8'h1F);
      wr_reg(2'd0, 8'h03);
      one_tick();
      check_eq("R6 flag not early", int'(cmp_flag), 0);
      @(negedge clk);
      check_eq("R6 flag one cycle after event", int'(cmp_flag), 1);
      repeat (3) @(negedge clk);
      check_eq("R7 flag sticky", int'(cmp_flag), 1);
      cmp_flag_clr = 1'b1;
      @(negedge clk);
      cmp_flag_clr = 1'b0;
      check_eq("R7 flag cleared", int'(cmp_flag), 0);
      wr_reg(2'd1, 8'h1F);
      one_tick();
      cmp_flag_clr = 1'b1;
      @(negedge clk);
      cmp_flag_clr = 1'b0;
      check_eq("R7 set wins over clear", int'(cmp_flag), 1);
   endtask

   task automatic t_fast_pwm();
      int hi, ed;
      do_reset();
      wr_reg(2'd2, 8'h40);
      wr_reg(2'd0, 8'h0B);
      tick_en = 1'b1;
      repeat (300) @(negedge clk);
      count_high(256, hi, ed); check_eq("R8 fast non-inverting high", hi, 64);
      wr_reg(2'd0, 8'h0F);
      repeat (300) @(negedge clk);
      count_high(256, hi, ed); check_eq("R8 fast inverting high", hi, 192);
      tick_en = 1'b0;
   endtask

   task automatic t_pc_pwm();
      int hi, ed;
      do_reset();
      wr_reg(2'd2, 8'h40);
      wr_reg(2'd0, 8'h09);
      tick_en = 1'b1;
      repeat (600) @(negedge clk);
      count_high(510, hi, ed); check_eq("R9 phase-correct non-inverting high", hi, 128);
      wr_reg(2'd0, 8'h0D);
      repeat (600) @(negedge clk);
      count_high(510, hi, ed); check_eq("R9 phase-correct inverting high", hi, 382);
      tick_en = 1'b0;
   endtask

   task automatic t_toggle_off();
      int hi, ed;
      do_reset();
      wr_reg(2'd2, 8'h10);
      wr_reg(2'd0, 8'h07);
      tick_en = 1'b1;
      repeat (300) @(negedge clk);
      count_high(512, hi, ed); check_eq("R10 toggles per 512 ticks", ed, 2);
      wr_reg(2'd0, 8'h03);
      count_high(600, hi, ed); check_eq("R11 off mode high count", hi, 0);
      tick_en = 1'b0;
   endtask

   task automatic t_buffer();
      int v;
      do_reset();
      wr_reg(2'd2, 8'h80);
      wr_reg(2'd0, 8'h03);
      tick_en = 1'b1;
      wait_cnt(8'h10);
      wr_reg(2'd2, 8'h40);
      rd_reg(2'd2, v); check_eq("R12 compare readback", v, 8'h40);
      wait_cnt(8'h60);
      check_eq("R12 staged value not active yet", int'(cmp_flag), 0);
      wait_cnt(8'h90);
      check_eq("R12 old value still active", int'(cmp_flag), 1);
      @(negedge clk); cmp_flag_clr = 1'b1;
      @(negedge clk); cmp_flag_clr = 1'b0;
      wait_cnt(8'h30);
      check_eq("R12 no early match after wrap", int'(cmp_flag), 0);
      wait_cnt(8'h50);
      check_eq("R12 new value active after wrap", int'(cmp_flag), 1);
      tick_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_updown();
      t_fast();
      t_tick_and_write();
      t_no_sw_match();
      t_flag();
      t_fast_pwm();
      t_pc_pwm();
      t_toggle_off();
      t_buffer();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule